// File: doc/BRIEF.md
# Three-Phase Regular-Sampled Sinusoidal PWM Generator

This block drives the six gates of a three-phase bridge inverter with pulse widths that follow a sine law. A single up/down counter forms a symmetric triangular carrier shared by all three phases. Each time the carrier reaches its lowest point, the block takes one sine sample per phase from an internal 64-entry table. It turns that sample into a compare threshold and loads it, so that the pulse of the coming carrier period sits centred on the carrier peak. The pulse width is Tc·(1+sin)/2.

Each phase produces an upper and a lower gate signal of opposite polarity. When dead time is switched on, each turn-on edge is held back until the phase's raw drive has been stable for a programmed number of cycles. The carrier top value, the number of carrier pulses per sine cycle and the dead-time settings are plain inputs. They are expected to change only while the block is disabled. A sticky flag marks each finished carrier period and stays set until a control loop acknowledges it.

Top module: `spwm3_gen`

## Requirements
- R1: Once enabled, the carrier count runs 0,1,…,P,P−1,…,1 and repeats, where P is `carrier_max` (P ≥ 1). One carrier period is 2P cycles. The period event is the cycle in which the count is 0, and the count never exceeds P.
- R2: `carrier_done` is set in the cycle after each period event and stays set until `flag_ack` is high while no period event occurs. A period event takes priority over an acknowledge. Reset clears the flag.
- R3: The sine sample for table slot j (0..63) is round(511·sin(2πj/64)), rounded half away from zero. A phase index p maps to slot (p·64)/N with integer division, where N is `pulses_per_cycle`.
- R4: The compare value of a phase is floor(P·(511+s)/1022) for sample s. It is loaded only at a period event and stays constant for the whole following carrier period.
- R5: The raw drive of a phase is high while the carrier count is strictly greater than P minus its compare value C. The raw pulse is therefore 2C−1 cycles wide (0 when C = 0) and centred on the peak cycle. The gates show the raw drive one cycle later.
- R6: A pulse index starts at 0 on enable and steps by one at every period event, wrapping from N−1 to 0. The period that starts at the k-th event after enable (k counted from 0) uses index k mod N.
- R7: Phase 0 uses the pulse index i directly. Phase 1 uses (i + N/3) mod N and phase 2 uses (i + (2N)/3) mod N, with integer division.
- R8: With dead time off, while running, the lower gate of each phase is the exact complement of its upper gate.
- R9: With dead time on and count D, an upper or lower gate turns on only once the raw drive has held that level for D+1 consecutive cycles. An upper and a lower gate of the same phase are never on together.
- R10: From the cycle after `run_en` is sampled low, all six gates are low. The carrier count and the pulse index restart from 0 on the next enable, and the compare values rest at floor(P/2).
- R11: After reset, all gates and `carrier_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Run enable; low holds all gates off |
| carrier_max | input | CNT_W | Carrier top count P (half the carrier period) |
| pulses_per_cycle | input | IDX_W | Carrier pulses per sine cycle N |
| dead_cycles | input | DT_W | Dead-time count D |
| dead_on | input | 1 | Enables dead-time insertion |
| flag_ack | input | 1 | Clears the carrier-period flag |
| hi_gate | output | 3 | Upper switch drive, one bit per phase |
| lo_gate | output | 3 | Lower switch drive, one bit per phase |
| carrier_done | output | 1 | Sticky carrier-period flag |

## Verification
Slot 0 is the cycle in which `run_en` is first seen high, and it is the first period event. The compare values take their new values at the edge that ends that slot. The raw drive of slot c appears on the gates in slot c+1, with the dead-time qualification added at that same point. The flag rises in the slot after each event. The bench steps a slot model at every falling edge: it compares the outputs against the model state built from the previous slot's inputs, then drives new inputs and advances the model. Every result is therefore checked exactly one register stage after the slot that caused it. After a disable, the bench expects all gates low from the very next slot.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  localparam int SIN_AMP  = 511;
  localparam int TBL_BITS = 6;
  localparam int TBL_LEN  = 1 << TBL_BITS;
  localparam int QTR      = TBL_LEN / 4;

  // first quarter of the sine, amplitude SIN_AMP, slots 0..QTR
  function automatic int quarter_sin(input int q);
    case (q)
      0: return 0;     1: return 50;    2: return 100;   3: return 148;
      4: return 196;   5: return 241;   6: return 284;   7: return 324;
      8: return 361;   9: return 395;   10: return 425;  11: return 451;
      12: return 472;  13: return 489;  14: return 501;  15: return 509;
      default: return SIN_AMP;
    endcase
  endfunction

  // full-wave sample built from quarter symmetry
  function automatic int sine_at(input int j);
    int jj;
    jj = j % TBL_LEN;
    if (jj <= QTR)          return quarter_sin(jj);
    else if (jj <= 2 * QTR) return quarter_sin(2 * QTR - jj);
    else if (jj <= 3 * QTR) return -quarter_sin(jj - 2 * QTR);
    else                    return -quarter_sin(TBL_LEN - jj);
  endfunction

  // pulse index scaled onto the table length
  function automatic int tbl_index(input int p, input int n);
    if (n <= 0) return 0;
    return (p * TBL_LEN) / n;
  endfunction

  // compare value: period times (1+sin)/2
  function automatic int cmp_of(input int per, input int s);
    return (per * (SIN_AMP + s)) / (2 * SIN_AMP);
  endfunction
endpackage

// File: rtl/spwm_carrier.sv
module spwm_carrier #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [CNT_W-1:0] carrier_max,
  output logic [CNT_W-1:0] cnt,
  output logic             period_evt
);
  logic going_up;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_en) begin
      cnt      <= '0;
      going_up <= 1'b1;
    end else if (going_up) begin
      cnt <= cnt + 1'b1;
      if (cnt + 1'b1 == carrier_max) going_up <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
      if (cnt == {{(CNT_W-1){1'b0}}, 1'b1}) going_up <= 1'b1;
    end
  end

  assign period_evt = run_en && (cnt == '0);

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && carrier_max != '0) |-> cnt <= carrier_max);
endmodule

// File: rtl/spwm_ref.sv
module spwm_ref
  import spwm_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int IDX_W  = 8,
  parameter int PHASES = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         run_en,
  input  logic                         period_evt,
  input  logic [CNT_W-1:0]             carrier_max,
  input  logic [IDX_W-1:0]             pulses,
  output logic [PHASES-1:0][CNT_W-1:0] cmp_act
);
  localparam int SUM_W = IDX_W + 1;

  logic [IDX_W-1:0] idx;
  logic [SUM_W-1:0] idx_next;

  assign idx_next = {1'b0, idx} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_en) idx <= '0;
    else if (period_evt)
      idx <= (idx_next >= {1'b0, pulses}) ? '0 : idx_next[IDX_W-1:0];
  end

  for (genvar ph = 0; ph < PHASES; ph++) begin : g_ph
    logic [SUM_W-1:0] off, sum, pidx;
    logic [CNT_W-1:0] shadow, active;

    always_comb begin
      off  = SUM_W'((ph * int'(pulses)) / PHASES);
      sum  = {1'b0, idx} + off;
      pidx = (sum >= {1'b0, pulses}) ? sum - {1'b0, pulses} : sum;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) shadow <= '0;
      else shadow <= CNT_W'(cmp_of(int'(carrier_max),
                       sine_at(tbl_index(int'(pidx), int'(pulses)))));
    end

    always_ff @(posedge clk) begin
      if (!rst_n || !run_en) active <= carrier_max >> 1;
      else if (period_evt)   active <= shadow;
    end

    assign cmp_act[ph] = active;
  end

  // R4
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !period_evt) |=> $stable(cmp_act));

  // R6
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulses != '0) |-> idx < pulses);
endmodule

// File: rtl/spwm_deadband.sv
module spwm_deadband #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_en,
  input  logic            raw,
  input  logic [DT_W-1:0] dead_cycles,
  input  logic            dead_on,
  output logic            hi,
  output logic            lo
);
  localparam logic [DT_W-1:0] RUN_MAX = '1;

  logic            act, level;
  logic [DT_W-1:0] run_len;
  logic            settled;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act     <= 1'b0;
      level   <= 1'b0;
      run_len <= RUN_MAX;
    end else begin
      act <= run_en;
      if (!run_en) begin
        level   <= 1'b0;
        run_len <= RUN_MAX;
      end else if (raw != level) begin
        level   <= raw;
        run_len <= '0;
      end else if (run_len != RUN_MAX) begin
        run_len <= run_len + 1'b1;
      end
    end
  end

  assign settled = !dead_on || (run_len >= dead_cycles);
  assign hi = act && level && settled;
  assign lo = act && !level && settled;

  // R9
  dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dead_on && dead_cycles != '0 && $rose(hi)) |-> !$past(lo));
endmodule

// File: rtl/spwm3_gen.sv
module spwm3_gen #(
  parameter int CNT_W = 12,
  parameter int IDX_W = 8,
  parameter int DT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [CNT_W-1:0] carrier_max,
  input  logic [IDX_W-1:0] pulses_per_cycle,
  input  logic [DT_W-1:0]  dead_cycles,
  input  logic             dead_on,
  input  logic             flag_ack,
  output logic [2:0]       hi_gate,
  output logic [2:0]       lo_gate,
  output logic             carrier_done
);
  localparam int PHASES = 3;

  logic [CNT_W-1:0]             cnt;
  logic                         period_evt;
  logic [PHASES-1:0][CNT_W-1:0] cmp_act;
  logic [PHASES-1:0]            raw_pwm;

  spwm_carrier #(.CNT_W(CNT_W)) u_car (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .carrier_max(carrier_max), .cnt(cnt), .period_evt(period_evt)
  );

  spwm_ref #(.CNT_W(CNT_W), .IDX_W(IDX_W), .PHASES(PHASES)) u_ref (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .period_evt(period_evt),
    .carrier_max(carrier_max), .pulses(pulses_per_cycle), .cmp_act(cmp_act)
  );

  for (genvar ph = 0; ph < PHASES; ph++) begin : g_leg
    assign raw_pwm[ph] = run_en && (cnt > carrier_max - cmp_act[ph]);

    spwm_deadband #(.DT_W(DT_W)) u_db (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .raw(raw_pwm[ph]),
      .dead_cycles(dead_cycles), .dead_on(dead_on),
      .hi(hi_gate[ph]), .lo(lo_gate[ph])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          carrier_done <= 1'b0;
    else if (period_evt) carrier_done <= 1'b1;
    else if (flag_ack)   carrier_done <= 1'b0;
  end

  // R2
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_evt |=> carrier_done);

  // R10
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (hi_gate == 3'b000 && lo_gate == 3'b000));
endmodule

// File: tb/tb_spwm3_gen.sv
`timescale 1ns/1ps
module tb_spwm3_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b0;
  logic [11:0] carrier_max = 12'd8;
  logic [7:0] pulses_per_cycle = 8'd12;
  logic [7:0] dead_cycles = 8'd0;
  logic       dead_on = 1'b0;
  logic       flag_ack = 1'b0;
  logic [2:0] hi_gate, lo_gate;
  logic       carrier_done;

  int total = 0;
  int bad = 0;

  spwm3_gen dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .carrier_max(carrier_max),
    .pulses_per_cycle(pulses_per_cycle), .dead_cycles(dead_cycles),
    .dead_on(dead_on), .flag_ack(flag_ack), .hi_gate(hi_gate),
    .lo_gate(lo_gate), .carrier_done(carrier_done)
  );

  always #2.5 clk = ~clk;

  // model state
  int  P, N, D;
  bit  DE;
  int  c;
  bit  running;
  bit  praw [3];
  int  runl [3];
  bit  e_hi [3];
  bit  e_lo [3];
  bit  e_act;
  bit  flag_m;

  // R3: own sine samples, rounded half away from zero
  function automatic int bsin(input int j);
    real r;
    r = 511.0 * $sin(2.0 * 3.14159265358979 * j / 64.0);
    if (r >= 0.0) return $rtoi(r + 0.5);
    return -$rtoi(-r + 0.5);
  endfunction

  // R4 R6 R7: compare of phase ph in period k after enable
  function automatic int bcmp(input int k, input int ph);
    int i, pi, j;
    i  = k % N;
    pi = (i + (ph * N) / 3) % N;
    j  = (pi * 64) / N;
    return (P * (511 + bsin(j))) / 1022;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic slot(input bit en_v, input bit ack_v);
    int  m, v;
    bit  raw, evt;
    int  exp_hi, exp_lo;
    string tag;
    exp_hi = 0; exp_lo = 0;
    for (int ph = 0; ph < 3; ph++) begin
      exp_hi[ph] = e_hi[ph];
      exp_lo[ph] = e_lo[ph];
    end
    if (!e_act) tag = "R10";
    else if (DE) tag = "R9";
    else tag = "R3 R4 R5 R6 R7 R8";
    check({lo_gate, hi_gate} == 6'((exp_lo << 3) | exp_hi), tag,
          {lo_gate, hi_gate}, (exp_lo << 3) | exp_hi);
    check(carrier_done == flag_m, "R1 R2", carrier_done, flag_m);
    run_en   = en_v;
    flag_ack = ack_v;
    evt = 1'b0;
    if (en_v) begin
      if (!running) begin c = 0; running = 1'b1; end
      m = c % (2 * P);
      v = (m <= P) ? m : 2 * P - m;
      evt = (m == 0);
      for (int ph = 0; ph < 3; ph++) begin
        // R5: high while count above P minus compare
        raw = (m != 0) && (v > P - bcmp(c / (2 * P), ph));
        if (raw != praw[ph]) begin praw[ph] = raw; runl[ph] = 0; end
        else if (runl[ph] < 255) runl[ph]++;
      end
      c++;
    end else begin
      running = 1'b0;
      for (int ph = 0; ph < 3; ph++) begin praw[ph] = 1'b0; runl[ph] = 255; end
    end
    e_act = en_v;
    for (int ph = 0; ph < 3; ph++) begin
      e_hi[ph] = e_act && praw[ph] && (!DE || runl[ph] >= D);
      e_lo[ph] = e_act && !praw[ph] && (!DE || runl[ph] >= D);
    end
    if (evt) flag_m = 1'b1;
    else if (ack_v) flag_m = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_run(input int p, input int n, input int d, input bit de, input int periods);
    P = p; N = n; D = d; DE = de;
    carrier_max = 12'(p); pulses_per_cycle = 8'(n);
    dead_cycles = 8'(d); dead_on = de;
    slot(1'b0, 1'b0);
    slot(1'b0, 1'b0);
    for (int s = 0; s < 2 * p * periods + 1; s++)
      slot(1'b1, ($urandom % 4) == 0);
    slot(1'b0, 1'b0);
    slot(1'b0, 1'b0);
    slot(1'b0, 1'b1);
  endtask

  initial begin
    #(5.0 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    P = 8; N = 12; D = 0; DE = 1'b0; c = 0; running = 1'b0;
    e_act = 1'b0; flag_m = 1'b0;
    for (int ph = 0; ph < 3; ph++) begin
      praw[ph] = 1'b0; runl[ph] = 255; e_hi[ph] = 1'b0; e_lo[ph] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state
    check(hi_gate == 3'b000 && lo_gate == 3'b000, "R11", {lo_gate, hi_gate}, 0);
    check(carrier_done == 1'b0, "R11", carrier_done, 0);
    // directed corners
    do_run(8, 12, 0, 1'b0, 14);  // full sine cycle plus wrap
    do_run(1, 1, 0, 1'b0, 6);    // smallest carrier, single pulse
    do_run(5, 3, 2, 1'b1, 5);    // dead time
    do_run(6, 4, 20, 1'b1, 5);   // dead time longer than any pulse
    do_run(3, 2, 0, 1'b1, 4);    // dead enabled with zero count
    do_run(40, 64, 1, 1'b1, 66); // table slot per index
    // random configurations
    for (int r = 0; r < 8; r++)
      do_run(1 + $urandom % 30, 1 + $urandom % 24, $urandom % 6,
             1'($urandom % 2), 3 + $urandom % 26);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule